// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block is a 64-bit integer datapath that treats each operand as a row of equal-width integer elements and applies one operation to every element in the same cycle. The element width is chosen per request: eight 8-bit elements, four 16-bit elements or two 32-bit elements. Add and subtract run on one shared byte-sliced adder whose carry chain is cut at the lane edges chosen for that request. Shifts move every lane by the same count. Three rearranging operations are also supported: an interleave of the lower elements, an interleave of the upper elements, and a narrowing pack.

A request is presented with `req_valid` high together with both operands, the lane-size code, the opcode and the shift count. The result, the valid strobe and an error flag are registered and appear one clock later. If no request is presented, the result and the error flag keep their previous values. An unsupported lane-size code produces a zero result and sets the error flag.

Top module: `simd_lane_alu`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, `res` is all zeros and `err` is 0.
- R2: A request accepted on a rising edge gives its result on `res`, with `res_valid` high, at the next rising edge. While `req_valid` is low, `res_valid` is 0 and `res` and `err` keep their values.
- R3: Lane-size codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. Lane i holds bits [i*w +: w]. Opcode 0 (add) gives, in every lane, (a_i + b_i) mod 2^w. No carry passes from one lane into the next.
- R4: Opcode 1 (subtract) gives (a_i - b_i) mod 2^w in every lane. No borrow passes between lanes.
- R5: Opcode 2 (left shift) shifts every lane of a left by the same 6-bit count `shamt`. A count of w or more gives zero.
- R6: Opcode 3 (logical right shift) shifts every lane of a right and fills with zeros. A count of w or more gives zero.
- R7: Opcode 4 (arithmetic right shift) shifts every lane of a right and fills with the lane's sign bit. A count of w or more gives a lane of copies of the sign bit.
- R8: Opcode 5 (interleave low) takes the lower n/2 elements of a and of b. Result lane 2j is a_j and result lane 2j+1 is b_j, so a_0 lands in lane 0.
- R9: Opcode 6 (interleave high) works like R8 but uses the upper elements: result lane 2j is a_(n/2+j) and result lane 2j+1 is b_(n/2+j).
- R10: Opcode 7 (pack) truncates every element to its low w/2 bits. The packed elements of a, in order, fill the low 32 bits of the result, and those of b fill the high 32 bits.
- R11: Lane-size code 3 gives an all-zero result with `err` = 1, whatever the opcode. Any legal code gives `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| opa | input | 64 | First packed operand |
| opb | input | 64 | Second packed operand |
| lane_sz | input | 2 | Element width code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: illegal) |
| opcode | input | 3 | Operation select (0 add … 7 pack) |
| shamt | input | 6 | Shift count applied to every lane |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res | output | 64 | Registered packed result |
| err | output | 1 | Registered illegal-size flag |

## Verification
All eight opcodes are swept across all four lane-size codes, using hand-picked operands and pseudo-random ones, and every result is compared with a lane-by-lane arithmetic model. Operands such as 0x80 and 0x7F in every byte, and all-ones, separate a carry or borrow that is cut at a lane edge from one that leaks into the next lane, and they show which lane size the shared adder actually used. For every shift opcode the count is stepped from 0 to 63, so each lane width is tried below, at and above its limit, and the sign fill on negative lanes is seen. Distinct byte patterns such as 0123456789ABCDEF tell apart the interleave order, the choice of the low or high half, and the pack truncation. Separate checks cover the hold behaviour while idle and the error flag clearing again after an illegal request.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_SAR  = 3'd4,
    OP_UNLO = 3'd5,
    OP_UNHI = 3'd6,
    OP_PACK = 3'd7
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_BAD = 2'd3
  } lane_sz_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lane_sz_e          sz,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] bx;
  logic [NB-1:0]     cout;

  assign bx = sub ? ~b : b;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam bit EDGE16 = (k % 2) == 0;
    localparam bit EDGE32 = (k % 4) == 0;
    logic lane_start;
    logic cin;

    assign lane_start = (sz == SZ_8) || (sz == SZ_16 && EDGE16) || EDGE32;

    if (k == 0) begin : g_first
      assign cin = sub;
    end else begin : g_rest
      assign cin = lane_start ? sub : cout[k-1];
    end

    if (k == NB - 1) begin : g_top
      assign y[k*8 +: 8] = a[k*8 +: 8] + bx[k*8 +: 8] + {7'd0, cin};
      assign cout[k]     = 1'b0;
    end else begin : g_mid
      logic [8:0] s;
      assign s           = {1'b0, a[k*8 +: 8]} + {1'b0, bx[k*8 +: 8]} + {8'd0, cin};
      assign y[k*8 +: 8] = s[7:0];
      assign cout[k]     = s[8];
    end
  end
endmodule

// File: rtl/simd_shift.sv
module simd_shift
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 6
) (
  input  logic [DATA_W-1:0] a,
  input  lane_sz_e          sz,
  input  simd_op_e          kind,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] y
);
  logic [NUM_SIZES-1:0][DATA_W-1:0] rsz;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W = 8 << g;
    localparam int N = DATA_W / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0]        lane;
      logic signed [W-1:0] sar;
      assign lane = a[i*W +: W];
      assign sar  = $signed(lane) >>> shamt;
      assign rsz[g][i*W +: W] = (kind == OP_SHL) ? (lane << shamt) :
                                (kind == OP_SHR) ? (lane >> shamt) : sar;
    end
  end

  always_comb begin
    case (sz)
      SZ_8:    y = rsz[0];
      SZ_16:   y = rsz[1];
      SZ_32:   y = rsz[2];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_permute.sv
module simd_permute
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lane_sz_e          sz,
  input  simd_op_e          kind,
  output logic [DATA_W-1:0] y
);
  logic [NUM_SIZES-1:0][DATA_W-1:0] lo, hi, pk;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W = 8 << g;
    localparam int N = DATA_W / W;
    localparam int H = W / 2;
    for (genvar j = 0; j < N / 2; j++) begin : g_pair
      assign lo[g][(2*j)*W   +: W] = a[j*W +: W];
      assign lo[g][(2*j+1)*W +: W] = b[j*W +: W];
      assign hi[g][(2*j)*W   +: W] = a[(N/2+j)*W +: W];
      assign hi[g][(2*j+1)*W +: W] = b[(N/2+j)*W +: W];
    end
    for (genvar i = 0; i < N; i++) begin : g_pack
      assign pk[g][i*H     +: H] = a[i*W +: H];
      assign pk[g][(N+i)*H +: H] = b[i*W +: H];
    end
  end

  always_comb begin
    y = '0;
    if (sz != SZ_BAD) begin
      case (kind)
        OP_UNLO: y = lo[sz];
        OP_UNHI: y = hi[sz];
        default: y = pk[sz];
      endcase
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        lane_sz,
  input  logic [2:0]        opcode,
  input  logic [SH_W-1:0]   shamt,
  output logic              res_valid,
  output logic [DATA_W-1:0] res,
  output logic              err
);
  lane_sz_e          szv;
  simd_op_e          opv;
  logic [DATA_W-1:0] y_add, y_sh, y_perm, y_sel;
  logic              bad_sz;

  assign szv    = lane_sz_e'(lane_sz);
  assign opv    = simd_op_e'(opcode);
  assign bad_sz = (szv == SZ_BAD);

  simd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(opa), .b(opb), .sz(szv), .sub(opv == OP_SUB), .y(y_add)
  );

  simd_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .a(opa), .sz(szv), .kind(opv), .shamt(shamt), .y(y_sh)
  );

  simd_permute #(.DATA_W(DATA_W)) u_permute (
    .a(opa), .b(opb), .sz(szv), .kind(opv), .y(y_perm)
  );

  always_comb begin
    case (opv)
      OP_ADD, OP_SUB:         y_sel = y_add;
      OP_SHL, OP_SHR, OP_SAR: y_sel = y_sh;
      default:                y_sel = y_perm;
    endcase
    if (bad_sz) y_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res       <= '0;
      err       <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res <= y_sel;
        err <= bad_sz;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid && $stable(res) && $stable(err));

  // R11
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lane_sz == 2'd3) |=> (err && res == '0));

  // R11
  good_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lane_sz != 2'd3) |=> !err);

  // R3
  add_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lane_sz == 2'd0 && opcode == 3'd0)
      |=> res[7:0] == $past(8'(opa[7:0] + opb[7:0])));

  // R5
  shl_big_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && opcode == 3'd2 && shamt >= SH_W'(32)) |=> res == '0);

  // R8
  unlo_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lane_sz == 2'd0 && opcode == 3'd5)
      |=> res[15:0] == {$past(opb[7:0]), $past(opa[7:0])});
endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] opa, opb;
  logic [1:0]  lane_sz;
  logic [2:0]  opcode;
  logic [5:0]  shamt;
  logic        res_valid;
  logic [63:0] res;
  logic        err;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu u_simd_lane_alu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .opa(opa), .opb(opb),
    .lane_sz(lane_sz), .opcode(opcode), .shamt(shamt),
    .res_valid(res_valid), .res(res), .err(err)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input int sz, input int op, input int sh);
    logic [63:0] r, mask, hm, ea, eb, e;
    int w, n, hw, src;
    logic sign;
    r = '0;
    if (sz > 2) return '0;
    w    = 8 << sz;
    n    = 64 / w;
    hw   = w / 2;
    mask = (64'd1 << w) - 64'd1;
    hm   = (64'd1 << hw) - 64'd1;
    if (op == 7) begin
      for (int i = 0; i < n; i++) begin
        r = r | (((a >> (i*w)) & hm) << (i*hw));
        r = r | (((b >> (i*w)) & hm) << ((n+i)*hw));
      end
      return r;
    end
    for (int i = 0; i < n; i++) begin
      ea = (a >> (i*w)) & mask;
      eb = (b >> (i*w)) & mask;
      e  = '0;
      case (op)
        0: e = (ea + eb) & mask;
        1: e = (ea - eb) & mask;
        2: e = (sh >= w) ? 64'd0 : ((ea << sh) & mask);
        3: e = (sh >= w) ? 64'd0 : (ea >> sh);
        4: begin
          sign = ea[w-1];
          if (sh >= w) e = sign ? mask : 64'd0;
          else e = (ea >> sh) | (sign ? (mask & ~(mask >> sh)) : 64'd0);
        end
        5, 6: begin
          src = ((op == 6) ? n/2 : 0) + i/2;
          e = ((((i % 2) == 0) ? a : b) >> (src*w)) & mask;
        end
        default: e = '0;
      endcase
      r = r | (e << (i*w));
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (sz=%0d op=%0d sh=%0d)",
               tag, act, exp, lane_sz, opcode, shamt);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (sz=%0d op=%0d)", tag, act, exp, lane_sz, opcode);
    end
  endtask

  task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                         input int sz, input int op, input int sh);
    @(negedge clk);
    opa = a; opb = b; lane_sz = 2'(sz); opcode = 3'(op); shamt = 6'(sh);
    req_valid = 1'b1;
    @(negedge clk);
    check64((sz == 3) ? "R11" : tag_of(op), res, model(a, b, sz, op, sh));
    check1("R11", err, (sz == 3));
    check1("R2", res_valid, 1'b1);
  endtask

  logic [63:0] pats [8];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_res;
    pats[0] = 64'h0000000000000000;
    pats[1] = 64'hFFFFFFFFFFFFFFFF;
    pats[2] = 64'h8080808080808080;
    pats[3] = 64'h7F7F7F7F7F7F7F7F;
    pats[4] = 64'h0123456789ABCDEF;
    pats[5] = 64'hFEDCBA9876543210;
    pats[6] = 64'h00FF00FF00FF00FF;
    pats[7] = 64'h8000000180000001;

    rst = 1'b1; req_valid = 1'b0; opa = '0; opb = '0;
    lane_sz = '0; opcode = '0; shamt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check1("R1", res_valid, 1'b0);
    check64("R1", res, 64'd0);
    check1("R1", err, 1'b0);

    // non-shift opcodes: fixed pairs and random pairs on every size code
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        if (op >= 2 && op <= 4) continue;
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) run_one(pats[i], pats[j], sz, op, 0);
        end
        for (int k = 0; k < 16; k++) begin
          logic [63:0] ra, rb;
          rng = next_rand(rng); ra = rng;
          rng = next_rand(rng); rb = rng;
          run_one(ra, rb, sz, op, 0);
        end
      end
    end

    // shift opcodes R5 R6 R7: every count 0..63
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 2; op <= 4; op++) begin
        for (int sh = 0; sh < 64; sh++) begin
          run_one(pats[2], pats[0], sz, op, sh);
          run_one(pats[5], pats[0], sz, op, sh);
          rng = next_rand(rng);
          run_one(rng, pats[1], sz, op, sh);
        end
      end
    end

    // R11: error clears on the next legal request
    run_one(pats[4], pats[5], 3, 0, 0);
    run_one(pats[4], pats[5], 0, 0, 0);

    // R2: idle cycles keep result and error, valid drops
    run_one(pats[4], pats[2], 1, 0, 0);
    hold_res = res;
    @(negedge clk);
    req_valid = 1'b0; opa = pats[1]; opb = pats[1]; lane_sz = 2'd3;
    @(negedge clk);
    check1("R2", res_valid, 1'b0);
    check64("R2", res, hold_res);
    check1("R2", err, 1'b0);
    @(negedge clk);
    check64("R2", res, hold_res);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule